// File: doc/BRIEF.md
# Collision Backoff Controller with Low-Priority Offset

This block is the retry engine of a half-duplex 10 Mb/s CSMA/CD transmitter. The frame engine tells it when a frame starts, when a collision is seen and when a frame finishes. After each collision the block counts the collision and draws a random delay, measured in whole slot times, from a free-running shift-register generator. It counts that delay down on a one-bit-time enable tick and then raises a one-cycle retry pulse. After the retry pulse, the frame engine starts the next attempt.

An optional low-priority mode gives the station a wider random range for its first three collisions, so it tends to yield to other stations. After the last allowed attempt the block gives up and marks the frame as aborted. It also keeps sticky status for the frame: the frame collided, the frame was aborted, a collision arrived after the slot window, the frame was sent cleanly, and how many collisions the frame has had. A new frame start clears all of this status.

Top module: `backoff_ctl`

## Requirements
- R1: After reset, all status outputs are 0, `col_count` is 0, `backoff_busy` is 0 and `retry_ready` is 0.
- R2: A `tx_start` pulse clears `st_sent`, `st_collided`, `st_aborted`, `st_late_col` and `col_count`, cancels any pending backoff, and begins a new attempt. It takes priority over every other input in the same cycle.
- R3: Each `col_event` during an attempt increments `col_count` by one and sets `st_collided`, which stays set until the next `tx_start`.
- R4: In normal mode (`offset_en`=0), after collision number n the delay before `retry_ready` is k·SLOT_BITS bit ticks, with k a whole number in the range 0 ≤ k < 2^min(n,10).
- R5: With `offset_en`=1, collisions 1 to 3 draw k from 0 ≤ k < 2^(n+3). From collision 4 on, the normal range of R4 applies.
- R6: `retry_ready` is a single-cycle pulse. It rises in the cycle the countdown reaches zero, which is the cycle after the collision when k=0. It appears only after a collision that was rescheduled, and a new attempt begins on it.
- R7: The collision that brings `col_count` to MAX_ATTEMPTS (16) ends the frame. `st_aborted` is set, `col_count` reads 16, no backoff is started and no `retry_ready` follows.
- R8: A collision that arrives SLOT_BITS or more bit ticks after the start of its attempt sets `st_late_col`. The frame is still rescheduled with a normal backoff. A collision within the first SLOT_BITS−3 ticks does not set the flag.
- R9: `tx_done` during an attempt ends the frame. It sets `st_sent` when `tx_underrun` is 0 and leaves it at 0 when `tx_underrun` is 1. `st_sent` and `st_aborted` are never both 1.
- R10: The backoff countdown advances only on cycles with `bit_tick`=1. Each tick-less cycle during the countdown adds one cycle to the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle enable per bit time |
| tx_start | input | 1 | Start of a new frame; clears status |
| col_event | input | 1 | Collision seen during the current attempt |
| tx_done | input | 1 | Current attempt ended without collision |
| tx_underrun | input | 1 | Qualifies `tx_done`: frame ended by data underrun |
| offset_en | input | 1 | Low-priority widened range for collisions 1 to 3 |
| retry_ready | output | 1 | One-cycle pulse: retransmission may start |
| backoff_busy | output | 1 | Backoff countdown in progress |
| st_sent | output | 1 | Frame completed without abort or underrun |
| st_collided | output | 1 | Frame collided at least once |
| st_aborted | output | 1 | Frame aborted after too many attempts |
| st_late_col | output | 1 | A collision arrived after the slot window |
| col_count | output | 5 | Collisions of the current frame |

## Verification
The assertions check several rules on every cycle. The retry pulse is one cycle long. A collision advances the count by exactly one. A frame start clears the status. An aborted frame always reads the maximum count. The late flag never appears without the collided flag. Sent and aborted never appear together. A countdown cannot finish on a cycle without a bit tick.

The random delay ranges can only be shown by the bench's scenarios. For each collision, the bench measures the delay and checks that it is a whole number of slots below the bound for that collision number. It checks the normal and low-priority bounds, the widened bound returning to normal at the fourth collision, and the abort on the sixteenth collision. It also checks late versus early collisions and delays stretched by missing ticks.

// File: rtl/bo_pkg.sv
package bo_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XMIT = 2'd1,
    ST_WAIT = 2'd2
  } bo_state_e;

  // Exponent of the backoff range after collision n.
  function automatic int unsigned bo_exponent(input int unsigned n,
                                              input logic        offs,
                                              input int unsigned cap,
                                              input int unsigned boost,
                                              input int unsigned boost_limit);
    int unsigned e;
    e = (offs && (n <= boost_limit)) ? (n + boost) : n;
    if (e > cap) e = cap;
    return e;
  endfunction

  // Mask of e low ones: draws land in 0 .. 2^e-1.
  function automatic int unsigned bo_span(input int unsigned e);
    return (32'd1 << e) - 32'd1;
  endfunction

endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= SEED;
    else if (q[0]) q <= (q >> 1) ^ TAPS;
    else           q <= q >> 1;
  end

  assign value = q;
endmodule

// File: rtl/bo_window.sv
module bo_window #(
  parameter int SLOT_BITS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic late
);
  localparam int WW = $clog2(SLOT_BITS + 1);
  logic [WW-1:0] cnt;

  assign late = (cnt == WW'(SLOT_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= '0;
    else if (tick && !late) cnt <= cnt + WW'(1);
  end
endmodule

// File: rtl/bo_slot_timer.sv
module bo_slot_timer #(
  parameter int SLOT_BITS = 512,
  parameter int SW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic          cancel,
  input  logic [SW-1:0] slots,
  output logic          busy,
  output logic          done
);
  localparam int TW = SW + $clog2(SLOT_BITS) + 1;

  logic [TW-1:0] cnt;
  logic          active;
  logic [TW-1:0] total;

  assign total = TW'(slots) * TW'(SLOT_BITS);
  assign busy  = active;
  assign done  = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || cancel) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= total;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else if (tick) cnt <= cnt - TW'(1);
    end
  end
endmodule

// File: rtl/backoff_ctl.sv
module backoff_ctl #(
  parameter int SLOT_BITS    = 512,
  parameter int MAX_ATTEMPTS = 16,
  parameter int EXP_CAP      = 10,
  parameter int BOOST        = 3,
  parameter int BOOST_LIMIT  = 3,
  parameter int LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int CNT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_start,
  input  logic             col_event,
  input  logic             tx_done,
  input  logic             tx_underrun,
  input  logic             offset_en,
  output logic             retry_ready,
  output logic             backoff_busy,
  output logic             st_sent,
  output logic             st_collided,
  output logic             st_aborted,
  output logic             st_late_col,
  output logic [CNT_W-1:0] col_count
);
  import bo_pkg::*;

  bo_state_e           state;
  logic [LFSR_W-1:0]   rnd;
  logic                late;
  logic                timer_done;
  logic                attempt_start;
  logic                col_hit;
  logic                fin_hit;
  logic                last_try;
  logic                resched;
  logic [CNT_W-1:0]    next_count;
  logic [EXP_CAP-1:0]  draw_mask;
  logic [EXP_CAP-1:0]  draw_slots;

  assign next_count    = col_count + CNT_W'(1);
  assign col_hit       = (state == ST_XMIT) && col_event && !tx_start;
  assign fin_hit       = (state == ST_XMIT) && tx_done && !col_event && !tx_start;
  assign last_try      = col_hit && (next_count == CNT_W'(MAX_ATTEMPTS));
  assign resched       = col_hit && !last_try;
  assign attempt_start = tx_start || timer_done;

  always_comb begin
    draw_mask  = EXP_CAP'(bo_span(bo_exponent(32'(next_count), offset_en,
                                              EXP_CAP, BOOST, BOOST_LIMIT)));
    draw_slots = rnd[EXP_CAP-1:0] & draw_mask;
  end

  bo_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .value(rnd)
  );

  bo_window #(.SLOT_BITS(SLOT_BITS)) u_window (
    .clk(clk), .rst_n(rst_n), .restart(attempt_start),
    .tick(bit_tick), .late(late)
  );

  bo_slot_timer #(.SLOT_BITS(SLOT_BITS), .SW(EXP_CAP)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .load(resched),
    .cancel(tx_start), .slots(draw_slots), .busy(backoff_busy),
    .done(timer_done)
  );

  assign retry_ready = timer_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      st_sent     <= 1'b0;
      st_collided <= 1'b0;
      st_aborted  <= 1'b0;
      st_late_col <= 1'b0;
      col_count   <= '0;
    end else if (tx_start) begin
      state       <= ST_XMIT;
      st_sent     <= 1'b0;
      st_collided <= 1'b0;
      st_aborted  <= 1'b0;
      st_late_col <= 1'b0;
      col_count   <= '0;
    end else begin
      if (col_hit) begin
        col_count   <= next_count;
        st_collided <= 1'b1;
        if (late) st_late_col <= 1'b1;
      end
      unique case (state)
        ST_XMIT: begin
          if (last_try) begin
            st_aborted <= 1'b1;
            state      <= ST_IDLE;
          end else if (resched) begin
            state <= ST_WAIT;
          end else if (fin_hit) begin
            st_sent <= !tx_underrun;
            state   <= ST_IDLE;
          end
        end
        ST_WAIT: if (timer_done) state <= ST_XMIT;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/backoff_ctl_chk.sv
module backoff_ctl_chk #(
  parameter int MAX_ATTEMPTS = 16,
  parameter int CNT_W        = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             tx_start,
  input logic             col_hit,
  input logic             retry_ready,
  input logic             backoff_busy,
  input logic             st_sent,
  input logic             st_collided,
  input logic             st_aborted,
  input logic             st_late_col,
  input logic [CNT_W-1:0] col_count
);
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (col_count == '0) && !st_collided && !st_aborted &&
                 !st_late_col && !st_sent && !retry_ready);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_hit |=> (col_count == $past(col_count) + CNT_W'(1)) && st_collided);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_ready |=> !retry_ready);

  assert_abort_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_aborted |-> (col_count == CNT_W'(MAX_ATTEMPTS)) && !backoff_busy);

  assert_late_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_late_col |-> st_collided);

  assert_sent_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_sent && st_aborted));

  assert_tick_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff_busy && !retry_ready && !bit_tick && !tx_start) |=> !retry_ready);
endmodule

bind backoff_ctl backoff_ctl_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_start(tx_start),
  .col_hit(col_hit), .retry_ready(retry_ready), .backoff_busy(backoff_busy),
  .st_sent(st_sent), .st_collided(st_collided), .st_aborted(st_aborted),
  .st_late_col(st_late_col), .col_count(col_count)
);

// File: tb/backoff_ctl_test.sv
`timescale 1ns/1ps
module backoff_ctl_test;
  localparam int SB   = 4;
  localparam int MAXA = 16;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b1, tx_start = 1'b0;
  logic col_event = 1'b0, tx_done = 1'b0, tx_underrun = 1'b0, offset_en = 1'b0;
  logic retry_ready, backoff_busy, st_sent, st_collided, st_aborted, st_late_col;
  logic [4:0] col_count;

  backoff_ctl #(.SLOT_BITS(SB), .MAX_ATTEMPTS(MAXA)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_start(tx_start),
    .col_event(col_event), .tx_done(tx_done), .tx_underrun(tx_underrun),
    .offset_en(offset_en), .retry_ready(retry_ready), .backoff_busy(backoff_busy),
    .st_sent(st_sent), .st_collided(st_collided), .st_aborted(st_aborted),
    .st_late_col(st_late_col), .col_count(col_count)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int start; int stall; int max_slots; int exp_cnt;} exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Range exponent, restated from R4/R5.
  function automatic int range_exp(input int n, input bit offs);
    int e;
    e = (offs && n <= 3) ? n + 3 : n;
    return (e > 10) ? 10 : e;
  endfunction

  // Monitor: pop the expected item at each retry pulse and compare.
  bit prev_rr = 0;
  always @(negedge clk) begin
    exp_t it;
    int m;
    int t;
    if (rst_n) begin
      if (prev_rr) check(!retry_ready, "R6 pulse width", int'(retry_ready), 0);
      if (retry_ready) begin
        if (q.size() == 0) check(0, "R6/R7 unexpected retry", 1, 0);
        else begin
          it = q.pop_front();
          m  = cyc - it.start - 1;
          t  = (m == 0) ? 0 : m - it.stall;
          check(t >= 0 && (t % SB) == 0, "R4/R10 whole slots", m, it.stall);
          check((t / SB) < it.max_slots, "R4/R5 slot range", t / SB, it.max_slots);
          check(col_count == 5'(it.exp_cnt), "R3 count at retry", int'(col_count), it.exp_cnt);
        end
      end
    end
    prev_rr = retry_ready;
  end

  task automatic start_frame();
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  // Driver: one collision of number n, expected item pushed to the queue.
  task automatic collide(input int n, input bit offs, input int stall, input int wait_before);
    repeat (wait_before) @(negedge clk);
    @(negedge clk);
    col_event = 1'b1;
    q.push_back('{cyc, stall, 1 << range_exp(n, offs), n});
    if (stall > 0) bit_tick = 1'b0;
    @(negedge clk); col_event = 1'b0;
    repeat (stall) @(negedge clk);
    bit_tick = 1'b1;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!st_sent && !st_collided && !st_aborted && !st_late_col, "R1 status",
          int'({st_sent, st_collided, st_aborted, st_late_col}), 0);
    check(col_count == 0 && !backoff_busy && !retry_ready, "R1 count/busy",
          int'(col_count), 0);

    // Normal mode: 15 rescheduled collisions, then abort on the 16th.
    start_frame();
    check(col_count == 0 && !st_collided, "R2 clear at start", int'(col_count), 0);
    collide(1, 0, 0, 0);
    check(st_collided, "R3 collided set", int'(st_collided), 1);
    check(!st_late_col, "R8 early collision not late", int'(st_late_col), 0);
    for (int n = 2; n <= 15; n++) collide(n, 0, 0, 0);
    @(negedge clk); col_event = 1'b1;
    @(negedge clk); col_event = 1'b0;
    check(st_aborted, "R7 aborted", int'(st_aborted), 1);
    check(col_count == 5'(MAXA), "R7 count", int'(col_count), MAXA);
    check(!backoff_busy, "R7 no backoff", int'(backoff_busy), 0);
    repeat (12) @(negedge clk);
    check(!st_sent, "R9 aborted not sent", int'(st_sent), 0);

    // Low-priority mode; widened range for 1..3, normal from 4.
    start_frame();
    check(!st_aborted && col_count == 0 && !st_collided, "R2 clear after abort",
          int'(col_count), 0);
    offset_en = 1'b1;
    for (int n = 1; n <= 5; n++) collide(n, 1, 0, 0);
    collide(6, 1, 0, 2 * SB + 2);
    check(st_late_col, "R8 late collision flagged", int'(st_late_col), 1);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    check(st_sent, "R9 sent after done", int'(st_sent), 1);
    check(st_collided && col_count == 6, "R3 status kept", int'(col_count), 6);

    // Underrun ends the frame without the sent flag.
    start_frame();
    check(!st_sent && !st_late_col, "R2 clear late/sent", int'({st_sent, st_late_col}), 0);
    @(negedge clk); tx_done = 1'b1; tx_underrun = 1'b1;
    @(negedge clk); tx_done = 1'b0; tx_underrun = 1'b0;
    check(!st_sent && !st_aborted, "R9 underrun not sent", int'(st_sent), 0);

    // Countdown stalled by missing ticks.
    offset_en = 1'b0;
    start_frame();
    for (int n = 1; n <= 4; n++) collide(n, 0, 2, 0);
    collide(5, 0, 5, 0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule